// File: doc/BRIEF.md
# Per-Priority Pause Request Scheduler

This block decides when flow-control pause frames go onto an Ethernet transmit link, for NQ priority queues. Each queue has a request level. That level is a bit in a software-writable field ORed with a bit of a hardware pause-insert input. A rising level asks the far end to stop that priority with an XOFF frame. A falling level releases it with an XON frame. A per-queue enable field qualifies both edges. While a request stays high, a per-queue retransmit enable and a hold-off count, measured in pause-quanta strobes, cause the XOFF to be sent again at fixed intervals.

Each queue is a three-state machine. The states are Q_IDLE, Q_XOFF (an XOFF is pending) and Q_XON (an XON is pending). The transitions are:
- Q_IDLE to Q_XOFF on a rising edge or when a retransmit falls due.
- Q_IDLE to Q_XON on a falling edge.
- Q_XOFF to Q_XON on a falling edge. This replaces the pending XOFF.
- Q_XON to Q_XOFF on a rising edge.
- Q_XOFF or Q_XON back to Q_IDLE when the arbiter takes the event.
- Any state to Q_IDLE when the queue is disabled.

A round-robin arbiter moves one pending event at a time into a single output slot. The slot holds the frame type and the queue index and drives a valid/ready handshake towards the frame inserter. The hold-off timer reloads when an XOFF is accepted at that handshake.

Top module: `pause_sched_top`

## Requirements
- R1: With queue n enabled, a 0-to-1 change of its request level produces exactly one event with pf_xoff=1 (XOFF) and pf_queue=n.
- R2: With queue n enabled, a 1-to-0 change of its request level produces exactly one event with pf_xoff=0 (XON) and pf_queue=n.
- R3: The request level of queue n is request-field bit n ORed with pause_insert[n]. A change in one source while the other is held high produces no event.
- R4: When enable bit n is 0, request edges and retransmits of queue n produce no event. Enabling the queue while its request is already high produces no event.
- R5: When retransmit enable bit n is 1 and the request stays high, an XOFF accepted for queue n reloads its timer with hold-off value n. After that many quanta_tick pulses, and not before, one more XOFF for queue n is offered.
- R6: When retransmit enable bit n is 0, no XOFF is re-sent for queue n, however many quanta_tick pulses arrive.
- R7: Each queue holds at most one pending event. If the request falls before a pending XOFF is taken into the output slot, only an XON is sent for that queue.
- R8: While pf_valid=1 and pf_ready=0, pf_valid, pf_xoff and pf_queue stay unchanged.
- R9: Pending events of several queues are granted in round-robin order. The queue after the last granted one is searched first, and at most one queue is taken per cycle.
- R10: The register map uses word addresses. 0x606 is the request field (reset 0). 0x607 is the retransmit enable field (reset all ones). 0x608 is the queue enable field (reset 0). 0x609+n is hold-off value n (reset HO_RST). Bit n of each field belongs to queue n, and every register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| pause_insert | input | NQ | Hardware request level per queue |
| quanta_tick | input | 1 | One-cycle pulse per pause quantum |
| pf_valid | output | 1 | Pause event offered to the inserter |
| pf_ready | input | 1 | Inserter accepts the event |
| pf_xoff | output | 1 | 1 = XOFF frame, 0 = XON frame |
| pf_queue | output | QW | Priority queue index of the event |

## Verification
The bench sweeps every queue through a rise and a fall from each request source, and checks that the two sources combine as an OR. A design that detected edges per source would emit spurious XON frames. The bench counts quanta ticks against the hold-off value: a timer that is off by one, or reloaded at take rather than at accept, moves the retransmit to the wrong tick. The bench also stalls the output with a second queue pending and drops that queue's request. A scheduler without replacement would emit a stale XOFF before the XON, and a slot that is not held would change its fields during the stall. Finally, it checks that grants over all queues rotate across two rounds, and that a queue disabled, or re-enabled while high, stays silent.

// File: rtl/pause_sched_pkg.sv
package pause_sched_pkg;
    typedef enum logic [1:0] {
        Q_IDLE = 2'd0,
        Q_XOFF = 2'd1,
        Q_XON  = 2'd2
    } qstate_e;

    localparam logic [11:0] ADDR_REQ    = 12'h606;
    localparam logic [11:0] ADDR_HOEN   = 12'h607;
    localparam logic [11:0] ADDR_EN     = 12'h608;
    localparam logic [11:0] ADDR_HOVAL0 = 12'h609;
endpackage

// File: rtl/pause_cfg_regs.sv
module pause_cfg_regs
    import pause_sched_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int HW     = 8,
    parameter int HO_RST = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [11:0]            addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic [NQ-1:0]          req_bits,
    output logic [NQ-1:0]          hoen_bits,
    output logic [NQ-1:0]          en_bits,
    output logic [NQ-1:0][HW-1:0]  hoval
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_bits  <= '0;
            hoen_bits <= '1;
            en_bits   <= '0;
            for (int q = 0; q < NQ; q++) hoval[q] <= HW'(HO_RST);
        end else if (wr_en) begin
            if (addr == ADDR_REQ)  req_bits  <= wdata[NQ-1:0];
            if (addr == ADDR_HOEN) hoen_bits <= wdata[NQ-1:0];
            if (addr == ADDR_EN)   en_bits   <= wdata[NQ-1:0];
            for (int q = 0; q < NQ; q++)
                if (addr == ADDR_HOVAL0 + 12'(q)) hoval[q] <= wdata[HW-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_REQ)  rdata[NQ-1:0] = req_bits;
        if (addr == ADDR_HOEN) rdata[NQ-1:0] = hoen_bits;
        if (addr == ADDR_EN)   rdata[NQ-1:0] = en_bits;
        for (int q = 0; q < NQ; q++)
            if (addr == ADDR_HOVAL0 + 12'(q)) rdata[HW-1:0] = hoval[q];
    end
endmodule

// File: rtl/pause_queue_fsm.sv
module pause_queue_fsm
    import pause_sched_pkg::*;
#(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          en,
    input  logic          hoen,
    input  logic [HW-1:0] hoval,
    input  logic          tick,
    input  logic          take,
    input  logic          xoff_done,
    output logic          pend,
    output logic          pend_xoff
);
    qstate_e       state, state_nx;
    logic          req_q;
    logic          armed;
    logic [HW-1:0] timer;
    logic          rise, fall, due;

    assign rise = req & ~req_q;
    assign fall = ~req & req_q;
    assign due  = armed & hoen & req & req_q & (timer == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= Q_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            Q_IDLE: begin
                if (!en)              state_nx = Q_IDLE;
                else if (rise || due) state_nx = Q_XOFF;
                else if (fall)        state_nx = Q_XON;
            end
            Q_XOFF: begin
                if (!en)       state_nx = Q_IDLE;
                else if (fall) state_nx = Q_XON;
                else if (take) state_nx = Q_IDLE;
            end
            Q_XON: begin
                if (!en)       state_nx = Q_IDLE;
                else if (rise) state_nx = Q_XOFF;
                else if (take) state_nx = Q_IDLE;
            end
            default: state_nx = Q_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pend      = (state != Q_IDLE);
        pend_xoff = (state == Q_XOFF);
    end

    // Edge history, retransmit arming and hold-off timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            armed <= 1'b0;
            timer <= '0;
        end else begin
            req_q <= req;
            if (!en || fall)                    armed <= 1'b0;
            else if (take && state == Q_XOFF)   armed <= 1'b0;
            else if (xoff_done)                 armed <= 1'b1;
            if (xoff_done)                      timer <= hoval;
            else if (tick && timer != '0)       timer <= timer - 1'b1;
        end
    end

    AST_RISE_XOFF: assert property (@(posedge clk) disable iff (!rst_n)
        en && rise |=> state == Q_XOFF);                                  // R1
    AST_FALL_XON: assert property (@(posedge clk) disable iff (!rst_n)
        en && fall |=> state == Q_XON);                                   // R2
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == Q_IDLE);                                         // R4
    AST_NO_RETX: assert property (@(posedge clk) disable iff (!rst_n)
        state == Q_IDLE && !hoen && !rise |=> state != Q_XOFF);           // R6
endmodule

// File: rtl/pause_rr_arb.sv
module pause_rr_arb #(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] pend,
    input  logic [NQ-1:0] pend_xoff,
    input  logic          out_ready,
    output logic [NQ-1:0] take,
    output logic [NQ-1:0] xoff_done,
    output logic          out_valid,
    output logic          out_xoff,
    output logic [QW-1:0] out_queue
);
    logic [QW-1:0] ptr;
    logic [QW-1:0] sel;
    logic          found;
    logic          load;

    assign load = !out_valid || out_ready;

    always_comb begin
        int idx;
        found = 1'b0;
        sel   = '0;
        for (int k = NQ - 1; k >= 0; k--) begin
            idx = int'(ptr) + k;
            if (idx >= NQ) idx = idx - NQ;
            if (pend[idx]) begin
                found = 1'b1;
                sel   = QW'(idx);
            end
        end
    end

    always_comb begin
        take      = '0;
        xoff_done = '0;
        if (found && load) take[sel] = 1'b1;
        if (out_valid && out_ready && out_xoff) xoff_done[out_queue] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_xoff  <= 1'b0;
            out_queue <= '0;
            ptr       <= '0;
        end else if (load) begin
            out_valid <= found;
            if (found) begin
                out_xoff  <= pend_xoff[sel];
                out_queue <= sel;
                ptr       <= (int'(sel) == NQ - 1) ? '0 : sel + 1'b1;
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_xoff) && $stable(out_queue)); // R8
    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));                                                    // R9
    AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (take & ~pend) == '0);                                              // R7
endmodule

// File: rtl/pause_sched_top.sv
module pause_sched_top
    import pause_sched_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int HW     = 8,
    parameter int HO_RST = 16,
    localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [11:0]   cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic [NQ-1:0] pause_insert,
    input  logic          quanta_tick,
    output logic          pf_valid,
    input  logic          pf_ready,
    output logic          pf_xoff,
    output logic [QW-1:0] pf_queue
);
    logic [NQ-1:0]         req_bits, hoen_bits, en_bits;
    logic [NQ-1:0][HW-1:0] hoval;
    logic [NQ-1:0]         pend, pend_xoff, take, xoff_done;
    logic [NQ-1:0]         req_lvl;

    assign req_lvl = req_bits | pause_insert;

    pause_cfg_regs #(.NQ(NQ), .HW(HW), .HO_RST(HO_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .req_bits(req_bits),
        .hoen_bits(hoen_bits), .en_bits(en_bits), .hoval(hoval)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        pause_queue_fsm #(.HW(HW)) u_q (
            .clk(clk), .rst_n(rst_n), .req(req_lvl[q]), .en(en_bits[q]),
            .hoen(hoen_bits[q]), .hoval(hoval[q]), .tick(quanta_tick),
            .take(take[q]), .xoff_done(xoff_done[q]),
            .pend(pend[q]), .pend_xoff(pend_xoff[q])
        );
    end

    pause_rr_arb #(.NQ(NQ), .QW(QW)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend), .pend_xoff(pend_xoff),
        .out_ready(pf_ready), .take(take), .xoff_done(xoff_done),
        .out_valid(pf_valid), .out_xoff(pf_xoff), .out_queue(pf_queue)
    );
endmodule

// File: tb/sim_pause_sched_top.sv
module sim_pause_sched_top;
    localparam int NQ = 4;
    localparam int QW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [11:0]   cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NQ-1:0] pause_insert = '0;
    logic          quanta_tick = 1'b0;
    logic          pf_valid;
    logic          pf_ready = 1'b1;
    logic          pf_xoff;
    logic [QW-1:0] pf_queue;

    int n_chk = 0;
    int n_bad = 0;
    int nlog  = 0;
    int lg_q [64];
    bit lg_x [64];
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pause_sched_top #(.NQ(NQ), .HW(8), .HO_RST(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pause_insert(pause_insert),
        .quanta_tick(quanta_tick), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_xoff(pf_xoff), .pf_queue(pf_queue)
    );

    // Event log, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready && nlog < 64) begin
            lg_q[nlog] = int'(pf_queue);
            lg_x[nlog] = pf_xoff;
            nlog++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        cyc(1);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input int exp, input string req);
        cfg_addr = a;
        #1;
        check(cfg_rdata == 32'(exp), req, int'(cfg_rdata), exp);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            quanta_tick = 1'b1; cyc(1);
            quanta_tick = 1'b0; cyc(2);
        end
    endtask

    task automatic one_ev(input int q, input bit x, input string req);
        check(nlog == 1, req, nlog, 1);
        if (nlog >= 1) begin
            check(lg_q[0] == q, req, lg_q[0], q);
            check(lg_x[0] == x, req, int'(lg_x[0]), int'(x));
        end
    endtask

    initial begin
        int first;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R10: reset values
        check(pf_valid == 1'b0, "R10 valid at reset", int'(pf_valid), 0);
        rd_chk(12'h606, 0, "R10 request reset");
        rd_chk(12'h607, 32'hF, "R10 hold-off enable reset");
        rd_chk(12'h608, 0, "R10 enable reset");
        rd_chk(12'h609, 16, "R10 hold-off value reset");
        wr(12'h60B, 32'h5A);
        rd_chk(12'h60B, 32'h5A, "R10 hold-off value readback");
        wr(12'h608, 32'hF);
        rd_chk(12'h608, 32'hF, "R10 enable readback");

        // R1 / R2 / R3 sweep: every queue, both sources
        for (int q = 0; q < NQ; q++) begin
            for (int src = 0; src < 2; src++) begin
                nlog = 0;
                if (src == 0) wr(12'h606, 32'(1) << q); else pause_insert[q] = 1'b1;
                cyc(6);
                one_ev(q, 1'b1, src == 0 ? "R1 rise from field" : "R3 rise from pin");
                nlog = 0;
                if (src == 0) wr(12'h606, 0); else pause_insert[q] = 1'b0;
                cyc(6);
                one_ev(q, 1'b0, src == 0 ? "R2 fall from field" : "R3 fall from pin");
            end
        end

        // R3: OR of the two sources
        nlog = 0;
        wr(12'h606, 32'h4);
        pause_insert[2] = 1'b1;
        cyc(6);
        one_ev(2, 1'b1, "R3 both high one XOFF");
        nlog = 0;
        pause_insert[2] = 1'b0;
        cyc(6);
        check(nlog == 0, "R3 pin drop while field high", nlog, 0);
        wr(12'h606, 0);
        cyc(6);
        one_ev(2, 1'b0, "R3 field drop gives XON");

        // R4: disabled queue
        wr(12'h608, 32'hB);
        nlog = 0;
        wr(12'h606, 32'h4); cyc(6);
        wr(12'h606, 0);     cyc(6);
        pause_insert[2] = 1'b1; tick(20);
        check(nlog == 0, "R4 disabled queue silent", nlog, 0);
        wr(12'h608, 32'hF); cyc(6);
        check(nlog == 0, "R4 enable while high silent", nlog, 0);
        pause_insert[2] = 1'b0; cyc(6);
        one_ev(2, 1'b0, "R4 fall after enable gives XON");

        // R5: retransmit after hold-off value ticks
        wr(12'h60A, 3);
        nlog = 0;
        wr(12'h606, 32'h2); cyc(6);
        check(nlog == 1, "R5 first XOFF", nlog, 1);
        tick(2); cyc(6);
        check(nlog == 1, "R5 no retransmit before interval", nlog, 1);
        tick(1); cyc(6);
        check(nlog == 2, "R5 retransmit at interval", nlog, 2);
        if (nlog >= 2) begin
            check(lg_q[1] == 1 && lg_x[1] == 1'b1, "R5 retransmit is XOFF q1", lg_q[1], 1);
        end
        tick(3); cyc(6);
        check(nlog == 3, "R5 second retransmit", nlog, 3);
        wr(12'h606, 0); cyc(6);
        check(nlog == 4 && lg_x[3] == 1'b0, "R5 release XON", nlog, 4);

        // R6: retransmit disabled
        wr(12'h607, 32'hD);
        nlog = 0;
        wr(12'h606, 32'h2); cyc(6);
        tick(12); cyc(4);
        check(nlog == 1, "R6 no retransmit when disabled", nlog, 1);
        wr(12'h606, 0); cyc(6);
        wr(12'h607, 32'hF);

        // R7 / R8: stall output, replace pending XOFF by XON
        pf_ready = 1'b0;
        nlog = 0;
        wr(12'h606, 32'h1); cyc(4);
        check(pf_valid && pf_xoff && pf_queue == 0, "R8 slot holds XOFF q0", int'(pf_queue), 0);
        wr(12'h606, 32'h3); cyc(3);
        wr(12'h606, 32'h1); cyc(10);
        check(pf_valid && pf_xoff && pf_queue == 0, "R8 slot stable under stall", int'(pf_xoff), 1);
        pf_ready = 1'b1; cyc(8);
        check(nlog == 2, "R7 two events only", nlog, 2);
        if (nlog >= 2) begin
            check(lg_q[0] == 0 && lg_x[0] == 1'b1, "R7 first XOFF q0", lg_q[0], 0);
            check(lg_q[1] == 1 && lg_x[1] == 1'b0, "R7 replaced by XON q1", int'(lg_x[1]), 0);
        end
        wr(12'h606, 0); cyc(6);

        // R9: round robin over all queues, two rounds
        nlog = 0;
        pf_ready = 1'b0;
        wr(12'h606, 32'hF); cyc(5);
        pf_ready = 1'b1; cyc(8);
        check(nlog == 4, "R9 four XOFF grants", nlog, 4);
        pf_ready = 1'b0;
        wr(12'h606, 0); cyc(5);
        pf_ready = 1'b1; cyc(8);
        check(nlog == 8, "R9 four XON grants", nlog, 8);
        if (nlog == 8) begin
            first = lg_q[0];
            for (int i = 0; i < 8; i++) begin
                check(lg_q[i] == (first + i) % NQ, "R9 rotation order", lg_q[i], (first + i) % NQ);
                check(lg_x[i] == (i < 4), "R9 frame type per round", int'(lg_x[i]), int'(i < 4));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule